// File: doc/BRIEF.md
# Relay Test Step Sequencer and Change-Set Checker

This block replays a stored list of test steps against a relay-based signalling installation that is under test. Each step applies one operation: it sets a single stimulus output to up or down. That output stands in for a panel button or for the simulated state of a field element, such as a point detection contact being dropped. After the stimulus is applied, the block watches a vector of relay-status inputs for a bounded observation window. Each input is synchronised and debounced before the block accepts a change. Every accepted change is streamed out with a millisecond timestamp, so that the test leaves evidence behind.

When the window closes, the set of relays that changed is compared against the step's expected change set. The expected set is a list of relays, each with the state it should end up in. Any expected change that did not happen, and any change that was not expected, makes the step fail. The verdict goes out as a result record with a valid/ready handshake. It carries separate counts of missing and unexpected changes. The next step does not start until the record has been taken.

Steps run in stored order until an end marker is reached or the store is exhausted. The block then raises a done flag and holds its pass and fail totals. A step can be flagged as covering the long route-cancellation delay. Such a step waits a fixed long interval, unless a quick-test input is high, in which case it uses its own short window.

Top module: `relay_step_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, `stim_out`, `res_valid`, `ev_valid`, `busy`, `done`, `pass_total` and `fail_total` are all zero.
- R2: A relay input change is accepted only after the synchronised input has differed from the accepted state for `deb_len` consecutive clock cycles (two synchroniser stages precede this), so a pulse shorter than that produces no event and leaves the accepted state unchanged.
- R3: On the cycle after a change is accepted, `ev_valid` is high, `ev_mask` marks exactly the relays that changed, `ev_level` shows the accepted state of every relay, and `ev_time` gives the elapsed milliseconds since reset, one millisecond being `TICKS_PER_MS` clock cycles.
- R4: A plan word is laid out from bit 0 upward as expected target levels (`N_RELAY` bits), expected change mask (`N_RELAY` bits), window (`WIN_W` bits), long-delay flag, stimulus level, stimulus select (log2 `N_STIM` bits) and end marker (top bit). Applying a step sets `stim_out[select]` to the stimulus level, and all other stimulus bits keep their value.
- R5: A step passes, with missing and unexpected counts of zero, when every relay in the mask changed during the window and ends at its target level, and no relay outside the mask changed.
- R6: `res_missing` counts the masked relays that either did not change during the window or did not end at their target level.
- R7: `res_extra` counts the relays outside the mask that changed at least once during the window, including a relay that changed and then returned.
- R8: The result record appears window+1 cycles after the stimulus output changes. For a step with the long-delay flag, it appears `CANCEL_TICKS`+1 cycles after that change, unless `quick_mode` is high, in which case the step's own window applies.
- R9: While `res_valid` is high and `res_ready` is low, the record fields stay stable and no further stimulus is applied.
- R10: An end-marker word, or the completion of the last plan slot, moves the block to done. `busy` is then low and `pass_total`/`fail_total` hold the number of passed and failed steps of that run.
- R11: Steps run in address order from 0, `res_step` carries the index of the step being reported, and a `start` pulse while idle or done begins a new run with the totals cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run from step 0 (honoured when idle or done) |
| quick_mode | input | 1 | Use the step's own window for long-delay steps |
| deb_len | input | 4 | Debounce length in cycles |
| plan_we | input | 1 | Plan store write enable |
| plan_addr | input | 4 | Plan store write address |
| plan_wdata | input | 38 | Plan word |
| relay_in | input | 8 | Raw relay status inputs |
| stim_out | output | 8 | Stimulus relay drives |
| ev_valid | output | 1 | Accepted change this cycle |
| ev_mask | output | 8 | Relays that changed |
| ev_level | output | 8 | Accepted relay states |
| ev_time | output | 32 | Millisecond timestamp |
| res_valid | output | 1 | Result record valid |
| res_ready | input | 1 | Result record taken |
| res_step | output | 4 | Step index of the record |
| res_pass | output | 1 | Step verdict |
| res_missing | output | 4 | Missing expected changes |
| res_extra | output | 4 | Unexpected changes |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass_total | output | 5 | Passed steps in the run |
| fail_total | output | 5 | Failed steps in the run |

## Verification
The assertions check several properties on every cycle. The event mask must equal the bit-wise difference between successive accepted states. At most one stimulus bit may move per cycle, and only while a run is active. A stalled result record must hold still. The verdict must agree with its two counts. The totals must stay frozen once the run is done. Other behaviours only show up in the bench's scenarios: the debounce latency and glitch rejection, the exact window lengths with and without quick mode, and the missing and unexpected counts for a relay that never moves, a stray relay, and a relay that moves and comes back. The bench also confirms the step order and the totals across two runs.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_WATCH,
        ST_REPORT,
        ST_DONE
    } seq_state_t;

    localparam int MAX_RELAYS = 64;

    // population count over a zero-extended relay vector
    function automatic int unsigned ones64(input logic [MAX_RELAYS-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAX_RELAYS; i++) begin
            n += 32'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rsc_timebase.sv
module rsc_timebase #(
    parameter int TICKS_PER_MS = 200000,
    parameter int MS_W         = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [MS_W-1:0] ms_now
);
    localparam int TK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

    logic [TK_W-1:0] tick_q;
    logic [MS_W-1:0] ms_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else if (tick_q == TK_W'(TICKS_PER_MS - 1)) begin
            tick_q <= '0;
            ms_q   <= ms_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign ms_now = ms_q;
endmodule

// File: rtl/rsc_debounce.sv
module rsc_debounce #(
    parameter int N_RELAY = 8,
    parameter int DEB_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DEB_W-1:0]   deb_len,
    input  logic [N_RELAY-1:0] raw,
    output logic [N_RELAY-1:0] level,
    output logic [N_RELAY-1:0] flip
);
    for (genvar g = 0; g < N_RELAY; g++) begin : g_relay
        logic             s1_q, s2_q, lvl_q, flip_q;
        logic [DEB_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                lvl_q  <= 1'b0;
                flip_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                s1_q   <= raw[g];
                s2_q   <= s1_q;
                flip_q <= 1'b0;
                if (s2_q != lvl_q) begin
                    if ((DEB_W+1)'(cnt_q) + 1'b1 >= (DEB_W+1)'(deb_len)) begin
                        lvl_q  <= s2_q;
                        flip_q <= 1'b1;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    cnt_q <= '0;
                end
            end
        end

        assign level[g] = lvl_q;
        assign flip[g]  = flip_q;
    end
endmodule

// File: rtl/rsc_plan_store.sv
module rsc_plan_store #(
    parameter int DEPTH = 16,
    parameter int W     = 38,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rsc_verdict.sv
module rsc_verdict #(
    parameter int N_RELAY = 8,
    parameter int CW      = 4
) (
    input  logic [N_RELAY-1:0] exp_mask,
    input  logic [N_RELAY-1:0] exp_level,
    input  logic [N_RELAY-1:0] seen,
    input  logic [N_RELAY-1:0] level,
    output logic [CW-1:0]      missing,
    output logic [CW-1:0]      extra,
    output logic               pass
);
    import rsc_pkg::*;

    logic [N_RELAY-1:0] met, miss_v, extra_v;

    always_comb begin
        met     = seen & ~(level ^ exp_level);
        miss_v  = exp_mask & ~met;
        extra_v = seen & ~exp_mask;
        missing = CW'(ones64(MAX_RELAYS'(miss_v)));
        extra   = CW'(ones64(MAX_RELAYS'(extra_v)));
        pass    = (miss_v == '0) && (extra_v == '0);
    end
endmodule

// File: rtl/relay_step_checker.sv
module relay_step_checker #(
    parameter int N_RELAY      = 8,
    parameter int N_STIM       = 8,
    parameter int PLAN_DEPTH   = 16,
    parameter int WIN_W        = 16,
    parameter int DEB_W        = 4,
    parameter int TICKS_PER_MS = 200000,
    parameter int MS_W         = 32,
    parameter int CANCEL_TICKS = 24000000,
    localparam int IDX_W   = $clog2(PLAN_DEPTH),
    localparam int TOT_W   = IDX_W + 1,
    localparam int SEL_W   = $clog2(N_STIM),
    localparam int CW      = $clog2(N_RELAY + 1),
    localparam int STEP_W  = 2*N_RELAY + WIN_W + 3 + SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               quick_mode,
    input  logic [DEB_W-1:0]   deb_len,
    input  logic               plan_we,
    input  logic [IDX_W-1:0]   plan_addr,
    input  logic [STEP_W-1:0]  plan_wdata,
    input  logic [N_RELAY-1:0] relay_in,
    output logic [N_STIM-1:0]  stim_out,
    output logic               ev_valid,
    output logic [N_RELAY-1:0] ev_mask,
    output logic [N_RELAY-1:0] ev_level,
    output logic [MS_W-1:0]    ev_time,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [IDX_W-1:0]   res_step,
    output logic               res_pass,
    output logic [CW-1:0]      res_missing,
    output logic [CW-1:0]      res_extra,
    output logic               busy,
    output logic               done,
    output logic [TOT_W-1:0]   pass_total,
    output logic [TOT_W-1:0]   fail_total
);
    import rsc_pkg::*;

    // plan word field positions
    localparam int F_MASK = N_RELAY;
    localparam int F_WIN  = 2*N_RELAY;
    localparam int F_LONG = F_WIN + WIN_W;
    localparam int F_LVL  = F_LONG + 1;
    localparam int F_SEL  = F_LVL + 1;
    localparam int F_END  = F_SEL + SEL_W;
    localparam int CW_LONG = $clog2(CANCEL_TICKS + 1);
    localparam int CNT_W   = (CW_LONG > WIN_W) ? CW_LONG : WIN_W;

    seq_state_t          state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    win_q;
    logic [N_RELAY-1:0]  seen_q, exp_mask_q, exp_level_q;
    logic [N_STIM-1:0]   stim_q;
    logic [STEP_W-1:0]   word;
    logic [N_RELAY-1:0]  deb_level, deb_flip, seen_now;
    logic [MS_W-1:0]     ms_now, ev_time_q;
    logic [CW-1:0]       v_missing, v_extra;
    logic                v_pass;
    logic [TOT_W-1:0]    pass_q, fail_q;
    logic                rv_q, rp_q;
    logic [IDX_W-1:0]    rs_q;
    logic [CW-1:0]       rm_q, rx_q;

    logic [SEL_W-1:0]    w_sel;
    logic [WIN_W-1:0]    w_win;

    rsc_timebase #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timebase (
        .clk(clk), .rst(rst), .ms_now(ms_now)
    );

    rsc_debounce #(.N_RELAY(N_RELAY), .DEB_W(DEB_W)) u_debounce (
        .clk(clk), .rst(rst), .deb_len(deb_len), .raw(relay_in),
        .level(deb_level), .flip(deb_flip)
    );

    rsc_plan_store #(.DEPTH(PLAN_DEPTH), .W(STEP_W), .AW(IDX_W)) u_plan (
        .clk(clk), .we(plan_we), .waddr(plan_addr), .wdata(plan_wdata),
        .raddr(idx_q), .rdata(word)
    );

    assign seen_now = seen_q | deb_flip;

    rsc_verdict #(.N_RELAY(N_RELAY), .CW(CW)) u_verdict (
        .exp_mask(exp_mask_q), .exp_level(exp_level_q), .seen(seen_now),
        .level(deb_level), .missing(v_missing), .extra(v_extra), .pass(v_pass)
    );

    assign w_sel = word[F_SEL +: SEL_W];
    assign w_win = word[F_WIN +: WIN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_time_q <= '0;
        end else begin
            ev_time_q <= ms_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            win_q       <= '0;
            seen_q      <= '0;
            exp_mask_q  <= '0;
            exp_level_q <= '0;
            stim_q      <= '0;
            pass_q      <= '0;
            fail_q      <= '0;
            rv_q        <= 1'b0;
            rp_q        <= 1'b0;
            rs_q        <= '0;
            rm_q        <= '0;
            rx_q        <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        idx_q   <= '0;
                        pass_q  <= '0;
                        fail_q  <= '0;
                        state_q <= ST_APPLY;
                    end
                end
                ST_APPLY: begin
                    if (word[F_END]) begin
                        state_q <= ST_DONE;
                    end else begin
                        if (32'(w_sel) < N_STIM) begin
                            stim_q[w_sel] <= word[F_LVL];
                        end
                        win_q       <= (word[F_LONG] && !quick_mode)
                                       ? CNT_W'(CANCEL_TICKS) : CNT_W'(w_win);
                        exp_level_q <= word[0 +: N_RELAY];
                        exp_mask_q  <= word[F_MASK +: N_RELAY];
                        seen_q      <= '0;
                        state_q     <= ST_WATCH;
                    end
                end
                ST_WATCH: begin
                    seen_q <= seen_now;
                    if (win_q == '0) begin
                        rv_q    <= 1'b1;
                        rs_q    <= idx_q;
                        rp_q    <= v_pass;
                        rm_q    <= v_missing;
                        rx_q    <= v_extra;
                        state_q <= ST_REPORT;
                    end else begin
                        win_q <= win_q - 1'b1;
                    end
                end
                ST_REPORT: begin
                    if (res_ready) begin
                        rv_q <= 1'b0;
                        if (rp_q) pass_q <= pass_q + 1'b1;
                        else      fail_q <= fail_q + 1'b1;
                        if (idx_q == IDX_W'(PLAN_DEPTH - 1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_APPLY;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign stim_out    = stim_q;
    assign ev_mask     = deb_flip;
    assign ev_valid    = |deb_flip;
    assign ev_level    = deb_level;
    assign ev_time     = ev_time_q;
    assign res_valid   = rv_q;
    assign res_step    = rs_q;
    assign res_pass    = rp_q;
    assign res_missing = rm_q;
    assign res_extra   = rx_q;
    assign busy        = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done        = (state_q == ST_DONE);
    assign pass_total  = pass_q;
    assign fail_total  = fail_q;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int N_RELAY = 8,
    parameter int N_STIM  = 8,
    parameter int IDX_W   = 4,
    parameter int CW      = 4,
    parameter int TOT_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [N_STIM-1:0]  stim_out,
    input logic [N_RELAY-1:0] ev_mask,
    input logic [N_RELAY-1:0] ev_level,
    input logic               res_valid,
    input logic               res_ready,
    input logic [IDX_W-1:0]   res_step,
    input logic               res_pass,
    input logic [CW-1:0]      res_missing,
    input logic [CW-1:0]      res_extra,
    input logic               busy,
    input logic               done,
    input logic [TOT_W-1:0]   pass_total,
    input logic [TOT_W-1:0]   fail_total
);
    // R3: reported mask is exactly the set of accepted-state bits that moved
    a_r3_mask_matches_level: assert property (@(posedge clk) disable iff (rst)
        (ev_level ^ $past(ev_level)) == ev_mask);

    // R4: one stimulus bit at a time
    a_r4_single_stim_change: assert property (@(posedge clk) disable iff (rst)
        $countones(stim_out ^ $past(stim_out)) <= 1);

    // R4: stimulus moves only during a run
    a_r4_stim_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        (stim_out != $past(stim_out)) |-> $past(busy));

    // R5: verdict agrees with its counts
    a_r5_verdict_consistent: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_pass == ((res_missing == '0) && (res_extra == '0))));

    // R9: stalled record holds
    a_r9_record_holds: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_step) &&
            $stable(res_pass) && $stable(res_missing) && $stable(res_extra)));

    // R9: a taken record is retired
    a_r9_record_retires: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ready) |=> !res_valid);

    // R10: done excludes activity
    a_r10_done_is_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !res_valid));

    // R10: totals frozen while done
    a_r10_totals_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(pass_total) && $stable(fail_total)));
endmodule

bind relay_step_checker rsc_checker #(
    .N_RELAY(N_RELAY), .N_STIM(N_STIM), .IDX_W(IDX_W), .CW(CW), .TOT_W(TOT_W)
) u_rsc_checker (
    .clk(clk), .rst(rst), .start(start), .stim_out(stim_out),
    .ev_mask(ev_mask), .ev_level(ev_level), .res_valid(res_valid),
    .res_ready(res_ready), .res_step(res_step), .res_pass(res_pass),
    .res_missing(res_missing), .res_extra(res_extra), .busy(busy),
    .done(done), .pass_total(pass_total), .fail_total(fail_total)
);

// File: tb/relay_step_checker_bench.sv
`timescale 1ns/1ps
module relay_step_checker_bench;
    localparam int NR = 8, NS = 8, DEPTH = 16, WW = 16, DW = 4;
    localparam int TPM = 10, MSW = 32, CANCEL = 300;
    localparam int SW = 2*NR + WW + 3 + 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst, start, quick_mode, plan_we, res_ready;
    logic [DW-1:0]  deb_len;
    logic [3:0]     plan_addr;
    logic [SW-1:0]  plan_wdata;
    logic [NR-1:0]  relay_in;
    logic [NS-1:0]  stim_out;
    logic           ev_valid, res_valid, res_pass, busy, done;
    logic [NR-1:0]  ev_mask, ev_level;
    logic [MSW-1:0] ev_time;
    logic [3:0]     res_step, res_missing, res_extra;
    logic [4:0]     pass_total, fail_total;

    relay_step_checker #(
        .N_RELAY(NR), .N_STIM(NS), .PLAN_DEPTH(DEPTH), .WIN_W(WW), .DEB_W(DW),
        .TICKS_PER_MS(TPM), .MS_W(MSW), .CANCEL_TICKS(CANCEL)
    ) u_relay_step_checker (
        .clk(clk), .rst(rst), .start(start), .quick_mode(quick_mode),
        .deb_len(deb_len), .plan_we(plan_we), .plan_addr(plan_addr),
        .plan_wdata(plan_wdata), .relay_in(relay_in), .stim_out(stim_out),
        .ev_valid(ev_valid), .ev_mask(ev_mask), .ev_level(ev_level),
        .ev_time(ev_time), .res_valid(res_valid), .res_ready(res_ready),
        .res_step(res_step), .res_pass(res_pass), .res_missing(res_missing),
        .res_extra(res_extra), .busy(busy), .done(done),
        .pass_total(pass_total), .fail_total(fail_total)
    );

    int checks = 0, errors = 0, off = 0, cyc = 0;
    logic [NS-1:0] stim_prev;

    task automatic check(input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // word builder following the field layout of R4
    function automatic logic [SW-1:0] mk(input bit endm, input int sel,
        input bit lvl, input bit lng, input int win,
        input logic [NR-1:0] mask, input logic [NR-1:0] tgt);
        return {endm, 3'(sel), lvl, lng, 16'(win), mask, tgt};
    endfunction

    // behavioural event model (R2 R3)
    int   m_s1 [NR], m_s2 [NR], m_st [NR], m_cnt [NR];
    int   m_ms = 0, m_tick = 0;
    logic m_evv;
    logic [NR-1:0]  m_evm, m_evl;
    logic [MSW-1:0] m_evt;

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NR; r++) begin
                m_s1[r] = 0; m_s2[r] = 0; m_st[r] = 0; m_cnt[r] = 0;
            end
            m_ms = 0; m_tick = 0; m_evv = 0; m_evm = '0; m_evl = '0; m_evt = '0;
        end else begin
            m_evm = '0;
            for (int r = 0; r < NR; r++) begin
                if (m_s2[r] != m_st[r]) begin
                    if (m_cnt[r] + 1 >= int'(deb_len)) begin
                        m_st[r] = m_s2[r]; m_cnt[r] = 0; m_evm[r] = 1'b1;
                    end else m_cnt[r]++;
                end else m_cnt[r] = 0;
                m_s2[r] = m_s1[r];
                m_s1[r] = int'(relay_in[r]);
                m_evl[r] = m_st[r][0];
            end
            m_evv = |m_evm;
            m_evt = MSW'(m_ms);
            if (m_tick == TPM - 1) begin m_tick = 0; m_ms++; end
            else m_tick++;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (ev_valid !== m_evv || ev_mask !== m_evm || ev_level !== m_evl ||
                ev_time !== m_evt) begin
                errors++;
                $display("FAIL R2 R3 event stream t=%0t actual=%0d/%0h/%0h/%0d expected=%0d/%0h/%0h/%0d",
                    $time, ev_valid, ev_mask, ev_level, ev_time, m_evv, m_evm, m_evl, m_evt);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        off++;
    endtask

    task automatic until_off(input int t);
        while (off < t) tick();
    endtask

    task automatic wr(input int a, input logic [SW-1:0] w);
        plan_we = 1'b1; plan_addr = 4'(a); plan_wdata = w;
        @(negedge clk);
        plan_we = 1'b0;
    endtask

    task automatic begin_step(input logic [NS-1:0] exp_stim);
        int guard = 0;
        while (stim_out == stim_prev && guard < 100) begin
            @(negedge clk); guard++;
        end
        off = 0;
        check("R4", "stimulus vector", stim_out, exp_stim);
    endtask

    task automatic finish_step(input int step, input int win_exp,
                               input bit ps, input int mi, input int ex);
        while (!res_valid && off < 1000) tick();
        check("R8", "window length", off, win_exp);
        check("R11", "step index", res_step, step);
        check("R5", "verdict", res_pass, ps);
        check("R6", "missing count", res_missing, mi);
        check("R7", "unexpected count", res_extra, ex);
        stim_prev = stim_out;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; quick_mode = 1'b0; plan_we = 1'b0;
        res_ready = 1'b0; deb_len = 4'd3; plan_addr = '0; plan_wdata = '0;
        relay_in = '0;
        repeat (4) @(negedge clk);
        check("R1", "stim_out in reset", stim_out, 0);
        check("R1", "res_valid in reset", res_valid, 0);
        check("R1", "busy/done in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "totals after reset", {pass_total, fail_total}, 0);
        check("R1", "ev_valid after reset", ev_valid, 0);

        wr(0, mk(0, 0, 1, 0, 40, 8'b0000_0011, 8'b0000_0011));
        wr(1, mk(0, 1, 1, 0, 40, 8'b0000_0101, 8'b0000_0100));
        wr(2, mk(0, 2, 1, 0, 40, 8'b0000_1000, 8'b0000_1000));
        wr(3, mk(0, 3, 1, 0, 40, 8'b0010_0000, 8'b0010_0000));
        wr(4, mk(0, 4, 1, 0, 40, 8'b0000_0010, 8'b0000_0000));
        wr(5, mk(0, 5, 1, 1, 40, 8'b1000_0000, 8'b1000_0000));
        wr(6, mk(1, 0, 0, 0, 0, 8'h00, 8'h00));

        stim_prev = stim_out;
        start = 1'b1; @(negedge clk); start = 1'b0;

        // step 0: both expected relays pick up -> pass (R5)
        begin_step(8'h01);
        until_off(5); relay_in[0] = 1'b1; relay_in[1] = 1'b1;
        while (!res_valid && off < 1000) tick();
        repeat (8) tick();
        check("R9", "record held under backpressure", res_valid, 1);
        check("R9", "no new stimulus while stalled", stim_out, 8'h01);
        off = off - 8;
        finish_step(0, 41, 1, 0, 0);

        // step 1: one of two expected changes missing (R6)
        begin_step(8'h03);
        until_off(5); relay_in[0] = 1'b0;
        finish_step(1, 41, 0, 1, 0);

        // step 2: stray relay change (R7)
        begin_step(8'h07);
        until_off(5); relay_in[3] = 1'b1; relay_in[4] = 1'b1;
        finish_step(2, 41, 0, 0, 1);

        // step 3: expected change plus a one-cycle glitch that must be rejected (R2)
        begin_step(8'h0F);
        until_off(5); relay_in[5] = 1'b1; relay_in[6] = 1'b1;
        tick(); relay_in[6] = 1'b0;
        finish_step(3, 41, 1, 0, 0);

        // step 4: relay drops then returns, ends at wrong level (R6)
        begin_step(8'h1F);
        until_off(5); relay_in[1] = 1'b0;
        until_off(20); relay_in[1] = 1'b1;
        finish_step(4, 41, 0, 1, 0);

        // step 5: long-delay step without quick mode (R8)
        begin_step(8'h3F);
        until_off(10); relay_in[7] = 1'b1;
        finish_step(5, CANCEL + 1, 1, 0, 0);

        repeat (3) @(negedge clk);
        check("R10", "done after end marker", done, 1);
        check("R10", "busy after end marker", busy, 0);
        check("R10", "pass total", pass_total, 3);
        check("R10", "fail total", fail_total, 3);

        // second run: long-delay step with quick mode, totals restart (R8 R11)
        wr(0, mk(0, 6, 1, 1, 40, 8'b1000_0000, 8'b0000_0000));
        wr(1, mk(1, 0, 0, 0, 0, 8'h00, 8'h00));
        quick_mode = 1'b1;
        stim_prev = stim_out;
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R11", "totals cleared on start", {pass_total, fail_total}, 0);
        begin_step(8'h7F);
        until_off(10); relay_in[7] = 1'b0;
        finish_step(0, 41, 1, 0, 0);
        repeat (3) @(negedge clk);
        check("R10", "done after second run", done, 1);
        check("R10", "second run pass total", pass_total, 1);
        check("R10", "second run fail total", fail_total, 0);

        summary();
        $finish;
    end
endmodule